// File: doc/BRIEF.md
# Programming Port Security and Status Logic

This block sits between the decoded command stream of a serial in-system programming port and the controller of a flash array. Each command arrives as an opcode, a target sector and a one-cycle valid strobe. The block decides whether the command may proceed. It answers with a one-cycle accept or reject pulse in the following cycle. An accepted array command is the start signal for the array controller.

Admission depends on four things: a security bit loaded from configuration at reset, one erase-protect bit per sector, whether the port is live, and whether the opcode is defined. The port is live when its pins are dedicated by a nonvolatile setting, or when they are enabled at run time and device reset is low. A rising edge of device reset, while the array is busy and the pins are not dedicated, gives a one-cycle abort pulse.

Two optional status pins report progress and errors. The ready pin is high when the array is idle. The error pin is active low and sticky. Both pins stay released until a port command switches them on. Another pair of port commands selects push-pull or open-drain drive for them.

Top module: `prog_port_guard`

## Requirements
- R1: After reset, cmd_accept, cmd_reject and op_abort are 0, both status output-enables are 0, the error flag is clear, the drive mode is push-pull, and the security state equals cfg_secure.
- R2: Opcodes are 1 program, 2 sector erase, 3 chip erase, 4 read, 5 verify, 6 port disable, 7 error clear, 8 status pins on, 9 open-drain, 10 push-pull. Each command sampled with cmd_valid gives exactly one of cmd_accept or cmd_reject, high for the one following cycle. Opcodes 0 and 11 to 15 are always rejected.
- R3: While secured, opcodes 1, 2, 4 and 5 are rejected. Chip erase is accepted and clears the security state from the next cycle on.
- R4: A sector erase whose target sector has its sector_prot bit set (bit index = cmd_sector) is rejected. A program to that sector is not affected.
- R5: A rejected command gives no accept and does not set the error flag.
- R6: An array_fail sample sets the error flag, so stat_err reads 0 from the next cycle. The flag stays set until one of the clear events of R7 or R8.
- R7: An accepted error-clear command clears the flag. If array_fail is sampled in the same cycle, the flag stays set.
- R8: A rising edge of dev_reset clears the flag only if a port-disable command was accepted before that edge. The edge consumes that arming. Without the arming, the edge leaves the flag unchanged.
- R9: stat_rdy is 0 while array_busy or sec_write_busy is high, and 1 otherwise, in the same cycle.
- R10: Until a status-pins-on command is accepted, stat_rdy_oe and stat_err_oe are 0.
- R11: Once the status pins are on, push-pull mode holds each output-enable at 1. Open-drain mode asserts a pin's output-enable only while that pin's level is 0.
- R12: Commands are rejected when pins_dedicated is 0 and either port_en is 0 or dev_reset is 1. With pins_dedicated at 1, dev_reset has no effect on admission.
- R13: op_abort is 1 in exactly the cycle where dev_reset rises while array_busy is 1 and pins_dedicated is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| cfg_secure | input | 1 | Security setting loaded at reset |
| pins_dedicated | input | 1 | Port pins dedicated by nonvolatile setting |
| port_en | input | 1 | Run-time port enable |
| dev_reset | input | 1 | Device reset level |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_sector | input | SEC_W | Target sector |
| sector_prot | input | NSEC | Per-sector erase protect bits |
| array_busy | input | 1 | Array program or erase in progress |
| sec_write_busy | input | 1 | Secondary array write in progress |
| array_fail | input | 1 | Program or erase failure event |
| cmd_accept | output | 1 | Command admitted (one cycle) |
| cmd_reject | output | 1 | Command refused (one cycle) |
| op_abort | output | 1 | Port operation aborted by reset |
| stat_rdy | output | 1 | Ready level |
| stat_rdy_oe | output | 1 | Ready pin output-enable |
| stat_err | output | 1 | Error level, active low |
| stat_err_oe | output | 1 | Error pin output-enable |

## Verification
Two functions can meet in one cycle. A new array failure can arrive in the same cycle as an accepted error-clear command. A device-reset edge can also arrive while the array is busy, which checks abort and admission together. The bench drives array_fail and the clear opcode on the same sampling edge and expects the error level to stay low. It then raises dev_reset during a busy phase, once with the pins dedicated and once without, and expects an abort pulse only in the second case. A behavioural model compares every output on every cycle.

// File: rtl/psg_pkg.sv
package psg_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_PROG   = 4'd1;
  localparam logic [OP_W-1:0] OP_SERASE = 4'd2;
  localparam logic [OP_W-1:0] OP_CHIP   = 4'd3;
  localparam logic [OP_W-1:0] OP_READ   = 4'd4;
  localparam logic [OP_W-1:0] OP_VERIFY = 4'd5;
  localparam logic [OP_W-1:0] OP_DIS    = 4'd6;
  localparam logic [OP_W-1:0] OP_ERRCLR = 4'd7;
  localparam logic [OP_W-1:0] OP_EXTON  = 4'd8;
  localparam logic [OP_W-1:0] OP_ODRAIN = 4'd9;
  localparam logic [OP_W-1:0] OP_PPULL  = 4'd10;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op >= OP_PROG) && (op <= OP_PPULL);
  endfunction

  // array access that the security state locks out
  function automatic logic op_locked(input logic [OP_W-1:0] op);
    return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_READ) || (op == OP_VERIFY);
  endfunction

  function automatic logic admit(input logic [OP_W-1:0] op, input logic secure,
                                 input logic prot_hit, input logic live);
    return live && op_known(op) && !(secure && op_locked(op))
           && !((op == OP_SERASE) && prot_hit);
  endfunction
endpackage

// File: rtl/psg_cmd_gate.sv
module psg_cmd_gate
  import psg_pkg::*;
#(
  parameter int NSEC  = 8,
  parameter int SEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_secure,
  input  logic             port_live,
  input  logic             cmd_valid,
  input  logic [OP_W-1:0]  cmd_op,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic [NSEC-1:0]  sector_prot,
  output logic             take_now,
  output logic             secure_q,
  output logic             cmd_accept,
  output logic             cmd_reject
);
  logic prot_hit;
  logic ok;

  assign prot_hit = sector_prot[cmd_sector];
  assign ok       = admit(cmd_op, secure_q, prot_hit, port_live);
  assign take_now = cmd_valid && ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secure_q   <= cfg_secure;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= take_now;
      cmd_reject <= cmd_valid && !ok;
      if (take_now && (cmd_op == OP_CHIP)) secure_q <= 1'b0;
    end
  end
endmodule

// File: rtl/psg_err_track.sv
module psg_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_evt,
  input  logic clr_cmd,
  input  logic dis_cmd,
  input  logic rst_rise,
  output logic rst_clr,
  output logic err_q
);
  logic armed_q;

  assign rst_clr = rst_rise && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (fail_evt)                err_q <= 1'b1;
      else if (clr_cmd || rst_clr) err_q <= 1'b0;
      if (dis_cmd)      armed_q <= 1'b1;
      else if (rst_clr) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/psg_pin_drv.sv
module psg_pin_drv (
  input  logic ext_on,
  input  logic od_mode,
  input  logic level,
  output logic pin,
  output logic oe
);
  assign pin = level;
  assign oe  = ext_on && (!od_mode || !level);
endmodule

// File: rtl/prog_port_guard.sv
module prog_port_guard
  import psg_pkg::*;
#(
  parameter int NSEC = 8,
  localparam int SEC_W = (NSEC > 1) ? $clog2(NSEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_secure,
  input  logic             pins_dedicated,
  input  logic             port_en,
  input  logic             dev_reset,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [SEC_W-1:0] cmd_sector,
  input  logic [NSEC-1:0]  sector_prot,
  input  logic             array_busy,
  input  logic             sec_write_busy,
  input  logic             array_fail,
  output logic             cmd_accept,
  output logic             cmd_reject,
  output logic             op_abort,
  output logic             stat_rdy,
  output logic             stat_rdy_oe,
  output logic             stat_err,
  output logic             stat_err_oe
);
  localparam int NPIN = 2;

  logic port_live, take_now, secure_q, err_q, rst_clr;
  logic drst_q, rst_rise;
  logic ev_clr, ev_dis, ev_exton, ev_od, ev_pp;
  logic ext_q, od_q;
  logic [NPIN-1:0] lvl, pin, oe;

  assign port_live = pins_dedicated || (port_en && !dev_reset);
  assign rst_rise  = dev_reset && !drst_q;
  assign op_abort  = rst_rise && !pins_dedicated && array_busy;

  assign ev_clr   = take_now && (cmd_op == OP_ERRCLR);
  assign ev_dis   = take_now && (cmd_op == OP_DIS);
  assign ev_exton = take_now && (cmd_op == OP_EXTON);
  assign ev_od    = take_now && (cmd_op == OP_ODRAIN);
  assign ev_pp    = take_now && (cmd_op == OP_PPULL);

  psg_cmd_gate #(.NSEC(NSEC), .SEC_W(SEC_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_secure(cfg_secure), .port_live(port_live),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sector(cmd_sector),
    .sector_prot(sector_prot), .take_now(take_now), .secure_q(secure_q),
    .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  psg_err_track u_err (
    .clk(clk), .rst_n(rst_n), .fail_evt(array_fail), .clr_cmd(ev_clr),
    .dis_cmd(ev_dis), .rst_rise(rst_rise), .rst_clr(rst_clr), .err_q(err_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drst_q <= 1'b0;
      ext_q  <= 1'b0;
      od_q   <= 1'b0;
    end else begin
      drst_q <= dev_reset;
      if (ev_exton) ext_q <= 1'b1;
      if (ev_od)      od_q <= 1'b1;
      else if (ev_pp) od_q <= 1'b0;
    end
  end

  assign lvl[0] = !(array_busy || sec_write_busy);
  assign lvl[1] = !err_q;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    psg_pin_drv u_drv (.ext_on(ext_q), .od_mode(od_q), .level(lvl[g]),
                       .pin(pin[g]), .oe(oe[g]));
  end

  assign stat_rdy    = pin[0];
  assign stat_rdy_oe = oe[0];
  assign stat_err    = pin[1];
  assign stat_err_oe = oe[1];
endmodule

// File: rtl/psg_chk.sv
module psg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       pins_dedicated,
  input logic       dev_reset,
  input logic       array_busy,
  input logic       sec_write_busy,
  input logic       array_fail,
  input logic       cmd_accept,
  input logic       cmd_reject,
  input logic       op_abort,
  input logic       stat_rdy,
  input logic       stat_rdy_oe,
  input logic       stat_err,
  input logic       stat_err_oe,
  input logic       secure_q,
  input logic       ext_q,
  input logic       od_q,
  input logic       ev_clr,
  input logic       rst_clr
);
  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));
  p_secure_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (secure_q && cmd_valid && (cmd_op == 4'd1)) |=> cmd_reject);
  p_no_err_on_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_err && !array_fail) |=> stat_err);
  p_fail_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    array_fail |=> !stat_err);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_err && !ev_clr && !rst_clr) |=> !stat_err);
  p_rdy_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (array_busy || sec_write_busy) |-> !stat_rdy);
  p_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_q |-> (!stat_rdy_oe && !stat_err_oe));
  p_od_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_q && od_q) |-> (!(stat_rdy_oe && stat_rdy) && !(stat_err_oe && stat_err)));
  p_reset_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !pins_dedicated && dev_reset) |=> !cmd_accept);
  p_abort_cond_r13: assert property (@(posedge clk) disable iff (!rst_n)
    op_abort |-> (!pins_dedicated && array_busy && dev_reset));
endmodule

bind prog_port_guard psg_chk i_psg_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .pins_dedicated(pins_dedicated), .dev_reset(dev_reset), .array_busy(array_busy),
  .sec_write_busy(sec_write_busy), .array_fail(array_fail), .cmd_accept(cmd_accept),
  .cmd_reject(cmd_reject), .op_abort(op_abort), .stat_rdy(stat_rdy),
  .stat_rdy_oe(stat_rdy_oe), .stat_err(stat_err), .stat_err_oe(stat_err_oe),
  .secure_q(secure_q), .ext_q(ext_q), .od_q(od_q), .ev_clr(ev_clr), .rst_clr(rst_clr)
);

// File: tb/test_prog_port_guard.sv
`timescale 1ns/1ps
module test_prog_port_guard;
  localparam int NSEC = 8;
  logic clk = 0, rst_n = 0, cfg_secure = 1, pins_dedicated = 0, port_en = 1, dev_reset = 0;
  logic cmd_valid = 0;
  logic [3:0] cmd_op = 0;
  logic [2:0] cmd_sector = 0;
  logic [NSEC-1:0] sector_prot = 0;
  logic array_busy = 0, sec_write_busy = 0, array_fail = 0;
  logic cmd_accept, cmd_reject, op_abort, stat_rdy, stat_rdy_oe, stat_err, stat_err_oe;
  int checks = 0, errors = 0;
  bit running = 0;

  always #2 clk = ~clk;

  prog_port_guard #(.NSEC(NSEC)) i_prog_port_guard (.*);

  // behavioural reference state
  bit m_sec, m_err, m_arm, m_ext, m_od, m_acc, m_rej, m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = cfg_secure; m_err = 0; m_arm = 0; m_ext = 0; m_od = 0;
      m_acc = 0; m_rej = 0; m_prev = 0;
    end else begin
      bit live, ok, rise, clr;
      int op;
      op   = cmd_op;
      live = pins_dedicated || (port_en && !dev_reset);
      ok   = live && op >= 1 && op <= 10;
      if (m_sec && (op == 1 || op == 2 || op == 4 || op == 5)) ok = 0;
      if (op == 2 && sector_prot[cmd_sector]) ok = 0;
      m_acc = cmd_valid && ok;
      m_rej = cmd_valid && !ok;
      rise = dev_reset && !m_prev;
      clr  = (m_acc && op == 7) || (rise && m_arm);
      if (rise && m_arm) m_arm = 0;
      if (m_acc && op == 6) m_arm = 1;
      if (array_fail) m_err = 1; else if (clr) m_err = 0;
      if (m_acc && op == 3) m_sec = 0;
      if (m_acc && op == 8) m_ext = 1;
      if (m_acc && op == 9) m_od = 1;
      if (m_acc && op == 10) m_od = 0;
      m_prev = dev_reset;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (running && rst_n) begin
    bit rl, el;
    rl = !(array_busy || sec_write_busy);
    el = !m_err;
    chk("R2 accept", cmd_accept, m_acc);
    chk("R5 reject", cmd_reject, m_rej);
    chk("R9 rdy", stat_rdy, rl);
    chk("R6 err", stat_err, el);
    chk("R11 rdy_oe", stat_rdy_oe, m_ext && (!m_od || !rl));
    chk("R10 err_oe", stat_err_oe, m_ext && (!m_od || !el));
    chk("R13 abort", op_abort, dev_reset && !m_prev && !pins_dedicated && array_busy);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic send(input int op, input int sec, input bit exp_acc, input string tag);
    step(); cmd_valid = 1; cmd_op = 4'(op); cmd_sector = 3'(sec);
    step(); cmd_valid = 0;
    @(negedge clk);
    chk(tag, cmd_accept, exp_acc);
    chk(tag, cmd_reject, !exp_acc);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1; running = 1;
    @(negedge clk);
    chk("R1 accept", cmd_accept, 0); chk("R1 reject", cmd_reject, 0);
    chk("R1 oe", stat_rdy_oe | stat_err_oe, 0); chk("R1 err", stat_err, 1);
    // R3: secured device
    send(1, 0, 0, "R3 prog locked");
    send(4, 0, 0, "R3 read locked");
    send(5, 0, 0, "R3 verify locked");
    send(2, 1, 0, "R3 erase locked");
    chk("R5 no err after reject", stat_err, 1);
    chk("R10 released", stat_rdy_oe | stat_err_oe, 0);
    send(8, 0, 1, "R10 pins on");
    chk("R11 pp oe", stat_rdy_oe & stat_err_oe, 1);
    send(3, 0, 1, "R3 chip erase");
    send(1, 0, 1, "R3 unlocked prog");
    send(0, 0, 0, "R2 opcode 0");
    send(15, 0, 0, "R2 opcode 15");
    // R4: protection
    sector_prot = 8'b0000_0100;
    send(2, 2, 0, "R4 protected erase");
    send(2, 3, 1, "R4 free erase");
    send(1, 2, 1, "R4 program protected");
    // R6/R11
    step(); array_fail = 1; step(); array_fail = 0;
    @(negedge clk); chk("R6 err set", stat_err, 0);
    send(9, 0, 1, "R11 open drain");
    chk("R11 od err drives", stat_err_oe, 1); chk("R11 od rdy released", stat_rdy_oe, 0);
    step(); sec_write_busy = 1; @(negedge clk);
    chk("R9 sec busy", stat_rdy, 0); chk("R11 od rdy drives", stat_rdy_oe, 1);
    step(); sec_write_busy = 0;
    // R7: clear and fail collide
    step(); cmd_valid = 1; cmd_op = 7; array_fail = 1;
    step(); cmd_valid = 0; array_fail = 0; @(negedge clk);
    chk("R7 fail wins", stat_err, 0);
    send(7, 0, 1, "R7 clear cmd");
    chk("R7 cleared", stat_err, 1);
    send(10, 0, 1, "R11 push pull");
    // R8
    step(); array_fail = 1; step(); array_fail = 0;
    step(); dev_reset = 1; step(); dev_reset = 0; @(negedge clk);
    chk("R8 unarmed reset", stat_err, 0);
    send(6, 0, 1, "R8 disable");
    step(); dev_reset = 1; step(); dev_reset = 0; @(negedge clk);
    chk("R8 armed reset", stat_err, 1);
    step(); array_fail = 1; step(); array_fail = 0;
    step(); dev_reset = 1; step(); dev_reset = 0; @(negedge clk);
    chk("R8 arming consumed", stat_err, 0);
    // R12/R13
    step(); array_busy = 1; dev_reset = 1; @(negedge clk);
    chk("R13 abort", op_abort, 1);
    chk("R9 busy", stat_rdy, 0);
    send(1, 0, 0, "R12 reset blocks");
    dev_reset = 0; pins_dedicated = 1;
    step(); dev_reset = 1; @(negedge clk);
    chk("R13 dedicated no abort", op_abort, 0);
    send(1, 0, 1, "R12 dedicated ignores reset");
    dev_reset = 0; array_busy = 0; pins_dedicated = 0; port_en = 0;
    send(1, 0, 0, "R12 port off");
    port_en = 1;
    send(1, 0, 1, "R12 port on");
    repeat (3) step();
    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule